// File: doc/BRIEF.md
# Periodic Interrupt Down-Counter Timer

This block is a memory-mapped down-counter that raises one level interrupt when it reaches a programmable compare value. Software programs it through five word registers: control, status, load, compare and count. Each tick the counter steps down by one. When it leaves zero it either refills from the load register or restarts from all-ones, depending on a control bit. The tick comes from one of three externally supplied tick-enable inputs, divided by a 12-bit prescaler. A fourth source code stops the counter altogether.

A compare match latches a sticky flag. Software clears the flag by writing a one to it. The interrupt output is the flag qualified by the compare interrupt enable and the timer enable. A soft reset, requested through a control bit, returns the data registers to their initial values and keeps only the enable-related control bits. A hardware reset clears everything.

Top module: `pit_timer`

## Requirements
- R1: Offsets 0 to 4 select control, status, load, compare and count. Count (offset 4) ignores writes. Offsets 5 to 7 read as zero and ignore writes.
- R2: Control keeps bits 25:0 of a write and bits 31:26 read as zero. The fields are: bit 0 enable, bit 1 restart-on-enable, bit 2 interrupt enable, bit 3 reload-from-load, bits 15:4 prescaler, bit 16 soft reset, bit 17 overwrite-on-load and bits 25:24 source.
- R3: Source code 01, 10 or 11 selects `srcTicks[0]`, `[1]` or `[2]`. A tick happens on every (prescaler+1)-th pulse of the selected source while enabled. Code 00 produces no ticks and the count holds.
- R4: `irq` is high exactly when the status flag, the interrupt enable and the enable are all set.
- R5: Writing 1 to status bit 0 clears the flag, and writing 0 has no effect. A match in the same cycle wins over the clear.
- R6: When a tick loads the counter with a value equal to compare, the status flag is set on that same clock edge. A bus write that replaces the counter in that cycle cancels that match.
- R7: A tick at count 0 loads the load register when reload-from-load is set, and 0xFFFFFFFF otherwise. In every other case the tick decrements the count.
- R8: A write that takes enable from 0 to 1 with restart-on-enable set loads the counter. It loads the load value if reload-from-load is set, and 0xFFFFFFFF otherwise.
- R9: While enable is 0 the count holds. Enabling with restart-on-enable clear resumes from the held value.
- R10: A load write while overwrite-on-load is set copies the written value into the counter on the same edge.
- R11: A control write with bit 16 set clears status and compare, sets load to 0xFFFFFFFF and clears the count, unless R8 applies to the same write. Of the written control bits it keeps only 0, 1 and 18 to 21, and bit 16 always reads 0.
- R12: After hardware reset, control, status, compare and count read 0, load reads 0xFFFFFFFF and `irq` is low.
- R13: A control write that changes the prescaler or the source restarts the divider. The next tick then comes exactly prescaler+1 selected pulses after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| busValid | input | 1 | Bus access valid this cycle |
| busWrite | input | 1 | Access is a write |
| busAddr | input | 3 | Word offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| srcTicks | input | 3 | Tick enables for source codes 01, 10 and 11 |
| irq | output | 1 | Level compare interrupt |

## Verification
The assertions assume single-cycle bus writes whose address and data are stable across the sampling edge. They also assume that `srcTicks` pulses are synchronous enables, sampled at the same edge as the bus. The status-rise check assumes the compare value it is judged against is the one held before that edge. The stimulus changes every input only on the falling clock edge. It generates the three sources as fixed-period pulse trains (every cycle, every second and every third cycle), so each source is a clean clock-enable. The bench's behavioural model is compared against the count and `irq` on every idle cycle.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int CR_W      = 26;
  localparam int PRE_W     = 12;
  localparam int SRC_W     = 2;
  localparam int NUM_SRC   = (1 << SRC_W) - 1;
  localparam int CR_EN     = 0;
  localparam int CR_MODE   = 1;
  localparam int CR_CIE    = 2;
  localparam int CR_RLD    = 3;
  localparam int CR_PRE_LO = 4;
  localparam int CR_SWR    = 16;
  localparam int CR_OVW    = 17;
  localparam int CR_SRC_LO = 24;
  localparam logic [CR_W-1:0] CR_SOFT_KEEP = 26'h03C_0003;
  localparam logic [CR_W-1:0] CR_SWR_MASK  = 26'h001_0000;

  localparam int OFS_CTRL = 0;
  localparam int OFS_STAT = 1;
  localparam int OFS_LOAD = 2;
  localparam int OFS_CMP  = 3;
  localparam int OFS_CNT  = 4;

  typedef struct packed {
    logic run;
    logic cntLoad;
    logic divClear;
  } pitStrobes_t;
endpackage

// File: rtl/pit_ctrl.sv
module pit_ctrl
  import pit_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [DATA_W-1:0] cntQ,
  input  logic              matchHit,
  output pitStrobes_t       strobes,
  output logic [DATA_W-1:0] cntValue,
  output logic [CR_W-1:0]   crQ,
  output logic              srFlag,
  output logic [DATA_W-1:0] lrQ,
  output logic [DATA_W-1:0] cmpQ,
  output logic              irq
);
  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  logic            wrEn, wrCtrl, wrStat, wrLoad, wrCmp;
  logic [CR_W-1:0] crIn, crStore;
  logic            softRst, enRise, restart, fieldChange;
  logic [DATA_W-1:0] loadBase;

  always_comb begin
    wrEn   = busValid & busWrite;
    wrCtrl = wrEn && (busAddr == ADDR_W'(OFS_CTRL));
    wrStat = wrEn && (busAddr == ADDR_W'(OFS_STAT));
    wrLoad = wrEn && (busAddr == ADDR_W'(OFS_LOAD));
    wrCmp  = wrEn && (busAddr == ADDR_W'(OFS_CMP));
  end

  assign crIn     = busWdata[CR_W-1:0];
  assign softRst  = wrCtrl & crIn[CR_SWR];
  assign crStore  = softRst ? (crIn & CR_SOFT_KEEP) : (crIn & ~CR_SWR_MASK);
  assign enRise   = wrCtrl & crStore[CR_EN] & ~crQ[CR_EN];
  assign restart  = enRise & crStore[CR_MODE];
  assign loadBase = softRst ? ALL_ONES : lrQ;
  assign fieldChange =
      (crStore[CR_PRE_LO +: PRE_W] != crQ[CR_PRE_LO +: PRE_W]) ||
      (crStore[CR_SRC_LO +: SRC_W] != crQ[CR_SRC_LO +: SRC_W]);

  always_comb begin
    strobes.run      = crQ[CR_EN];
    strobes.cntLoad  = softRst | restart | (wrLoad & crQ[CR_OVW]);
    strobes.divClear = softRst | (wrCtrl & fieldChange);
    if (restart)      cntValue = crStore[CR_RLD] ? loadBase : ALL_ONES;
    else if (softRst) cntValue = '0;
    else              cntValue = busWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crQ    <= '0;
      srFlag <= 1'b0;
      lrQ    <= ALL_ONES;
      cmpQ   <= '0;
    end else begin
      if (wrCtrl) crQ <= crStore;
      if (softRst)     srFlag <= 1'b0;
      else if (matchHit) srFlag <= 1'b1;
      else if (wrStat && busWdata[0]) srFlag <= 1'b0;
      if (softRst)     lrQ <= ALL_ONES;
      else if (wrLoad) lrQ <= busWdata;
      if (softRst)     cmpQ <= '0;
      else if (wrCmp)  cmpQ <= busWdata;
    end
  end

  always_comb begin
    case (busAddr)
      ADDR_W'(OFS_CTRL): busRdata = DATA_W'(crQ);
      ADDR_W'(OFS_STAT): busRdata = DATA_W'(srFlag);
      ADDR_W'(OFS_LOAD): busRdata = lrQ;
      ADDR_W'(OFS_CMP):  busRdata = cmpQ;
      ADDR_W'(OFS_CNT):  busRdata = cntQ;
      default:           busRdata = '0;
    endcase
  end

  assign irq = srFlag & crQ[CR_CIE] & crQ[CR_EN];
endmodule

// File: rtl/pit_datapath.sv
module pit_datapath
  import pit_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  pitStrobes_t        strobes,
  input  logic [DATA_W-1:0]  cntValue,
  input  logic [PRE_W-1:0]   presc,
  input  logic [SRC_W-1:0]   srcSel,
  input  logic [NUM_SRC-1:0] srcTicks,
  input  logic               reloadSel,
  input  logic [DATA_W-1:0]  lrQ,
  input  logic [DATA_W-1:0]  cmpQ,
  output logic [DATA_W-1:0]  cntQ,
  output logic               matchHit
);
  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  logic [NUM_SRC:0]    srcVec;
  logic                srcPulse, divWrap, tick;
  logic [PRE_W-1:0]    divQ;
  logic [DATA_W-1:0]   stepVal;

  assign srcVec   = {srcTicks, 1'b0};
  assign srcPulse = srcVec[srcSel];
  assign divWrap  = (divQ == presc);
  assign tick     = strobes.run & srcPulse & divWrap;
  assign stepVal  = (cntQ == '0) ? (reloadSel ? lrQ : ALL_ONES) : (cntQ - 1'b1);
  assign matchHit = tick & ~strobes.cntLoad & (stepVal == cmpQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divQ <= '0;
    end else if (strobes.divClear || !strobes.run || (srcSel == '0)) begin
      divQ <= '0;
    end else if (srcPulse) begin
      divQ <= divWrap ? '0 : divQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strobes.cntLoad) begin
      cntQ <= cntValue;
    end else if (tick) begin
      cntQ <= stepVal;
    end
  end
endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busValid,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [NUM_SRC-1:0] srcTicks,
  output logic               irq
);
  pitStrobes_t       strobes;
  logic [DATA_W-1:0] cntValue, cntQ, lrQ, cmpQ;
  logic [CR_W-1:0]   crQ;
  logic              srFlag, matchHit;

  pit_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .cntQ(cntQ), .matchHit(matchHit), .strobes(strobes), .cntValue(cntValue),
    .crQ(crQ), .srFlag(srFlag), .lrQ(lrQ), .cmpQ(cmpQ), .irq(irq)
  );

  pit_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cntValue(cntValue),
    .presc(crQ[CR_PRE_LO +: PRE_W]), .srcSel(crQ[CR_SRC_LO +: SRC_W]),
    .srcTicks(srcTicks), .reloadSel(crQ[CR_RLD]), .lrQ(lrQ), .cmpQ(cmpQ),
    .cntQ(cntQ), .matchHit(matchHit)
  );
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk
  import pit_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busWrite,
  input logic              irq,
  input logic [CR_W-1:0]   crQ,
  input logic              srFlag,
  input logic [DATA_W-1:0] cntQ,
  input logic [DATA_W-1:0] cmpQ
);
  // R4
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> srFlag);

  // R4
  irq_off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    !crQ[CR_EN] |-> !irq);

  // R9
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!crQ[CR_EN] && !(busValid && busWrite)) |=> $stable(cntQ));

  // R6
  flag_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(srFlag) |-> (cntQ == $past(cmpQ)));

  // R11
  soft_reset_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    !crQ[CR_SWR]);

  // R7
  step_by_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(cntQ) && !$past(busValid && busWrite)) |->
      ((cntQ == $past(cntQ) - 1'b1) || ($past(cntQ) == '0)));
endmodule

bind pit_timer pit_timer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .irq(irq), .crQ(crQ), .srFlag(srFlag), .cntQ(cntQ), .cmpQ(cmpQ)
);

// File: tb/pit_timer_bench.sv
module pit_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0, busWrite = 1'b0;
  logic [2:0]  busAddr = 3'd4;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [2:0]  srcTicks = '0;
  logic        irq;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pit_timer u_pit_timer (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .srcTicks(srcTicks), .irq(irq)
  );

  // source pulse trains: every cycle, every 2nd, every 3rd
  always @(negedge clk) begin
    cyc++;
    srcTicks <= {(cyc % 3 == 0), (cyc % 2 == 0), 1'b1};
  end

  // behavioural model
  logic [25:0] mCr;
  logic        mSr;
  logic [31:0] mLr, mCmp, mCnt;
  logic [11:0] mDiv;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCr = '0; mSr = 0; mLr = 32'hFFFF_FFFF; mCmp = '0; mCnt = '0; mDiv = '0;
    end else begin : step
      logic sp, tk, ovr, swr, sclr;
      logic [31:0] stepped, cntN, oldCmp;
      logic [25:0] oldCr, wcr;
      logic [11:0] divN;
      oldCr = mCr; oldCmp = mCmp; ovr = 0; swr = 0; sclr = 0;
      sp = (oldCr[25:24] == 2'd0) ? 1'b0 : srcTicks[oldCr[25:24] - 2'd1];
      tk = oldCr[0] && sp && (mDiv == oldCr[15:4]);
      stepped = (mCnt == 0) ? (oldCr[3] ? mLr : 32'hFFFF_FFFF) : mCnt - 1;
      cntN = tk ? stepped : mCnt;
      if (!oldCr[0] || oldCr[25:24] == 2'd0) divN = '0;
      else if (sp) divN = (mDiv == oldCr[15:4]) ? 12'd0 : mDiv + 12'd1;
      else divN = mDiv;
      if (busValid && busWrite) begin
        case (busAddr)
          3'd0: begin
            wcr = busWdata[25:0];
            swr = wcr[16];
            if (swr) begin
              wcr = wcr & 26'h03C_0003;
              mLr = 32'hFFFF_FFFF; mCmp = '0; cntN = '0; ovr = 1;
            end
            if (wcr[0] && !oldCr[0] && wcr[1]) begin
              cntN = wcr[3] ? mLr : 32'hFFFF_FFFF; ovr = 1;
            end
            if (swr || wcr[15:4] != oldCr[15:4] || wcr[25:24] != oldCr[25:24]) divN = '0;
            mCr = wcr;
          end
          3'd1: sclr = busWdata[0];
          3'd2: begin
            mLr = busWdata;
            if (oldCr[17]) begin cntN = busWdata; ovr = 1; end
          end
          3'd3: mCmp = busWdata;
          default: ;
        endcase
      end
      if (swr) mSr = 0;
      else if (tk && !ovr && stepped == oldCmp) mSr = 1;
      else if (sclr) mSr = 0;
      mCnt = cntN; mDiv = divN;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #5;
    if (rstN && !done) begin
      chk("R4 irq vs model", {31'd0, irq}, {31'd0, mSr & mCr[2] & mCr[0]});
      if (!busValid && busAddr == 3'd4)
        chk("R3/R7/R13 count vs model", busRdata, mCnt);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busValid = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 0; busWrite = 0; busAddr = 3'd4;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag);
    busAddr = a; #2;
    chk(tag, busRdata, e);
    @(negedge clk);
    busAddr = 3'd4;
  endtask

  task automatic rdv(input logic [2:0] a, output logic [31:0] v);
    busAddr = a; #2;
    v = busRdata;
    @(negedge clk);
    busAddr = 3'd4;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] x;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R12 reset state
    rd(0, 32'h0, "R12 control after reset");
    rd(1, 32'h0, "R12 status after reset");
    rd(2, 32'hFFFF_FFFF, "R12 load after reset");
    rd(3, 32'h0, "R12 compare after reset");
    rd(4, 32'h0, "R12 count after reset");
    chk("R12 irq low after reset", {31'd0, irq}, 32'd0);
    rd(5, 32'h0, "R1 unmapped offset reads zero");
    // R8 restart from load, R6 match
    wr(2, 32'd5);
    wr(3, 32'd2);
    wr(0, 32'h0100_000F);
    rd(4, 32'd5, "R8 restart loads load value");
    repeat (30) @(negedge clk);
    rd(1, 32'd1, "R6 flag set on match");
    // R5 status clearing
    wr(1, 32'd0);
    rd(1, 32'd1, "R5 writing zero keeps flag");
    wr(3, 32'd100);
    wr(1, 32'd1);
    rd(1, 32'd0, "R5 writing one clears flag");
    chk("R4 irq low once flag cleared", {31'd0, irq}, 32'd0);
    // R9 hold and resume
    wr(0, 32'h0100_000E);
    rdv(4, x);
    repeat (5) @(negedge clk);
    rd(4, x, "R9 count holds while disabled");
    wr(0, 32'h0100_000D);
    rd(4, x, "R9 resume from held value");
    // R10 overwrite, R7 free-run wrap
    wr(0, 32'h0102_0001);
    wr(2, 32'd2);
    rd(4, 32'd2, "R10 load write overwrites count");
    rd(4, 32'd1, "R7 decrement");
    rd(4, 32'd0, "R7 decrement to zero");
    rd(4, 32'hFFFF_FFFF, "R7 wrap to all ones without reload");
    // R3 prescaled source 2
    wr(0, 32'h0200_0031);
    repeat (40) @(negedge clk);
    // R13 divider restart on prescaler change
    wr(0, 32'h0100_0031);
    repeat (2) @(negedge clk);
    wr(0, 32'h0100_0021);
    rdv(4, x);
    rd(4, x, "R13 no tick after one pulse");
    rd(4, x, "R13 no tick after two pulses");
    rd(4, x - 32'd1, "R13 tick after prescaler+1 pulses");
    // R3 source off
    wr(0, 32'h0000_0031);
    rdv(4, x);
    repeat (10) @(negedge clk);
    rd(4, x, "R3 source code 00 stops counting");
    // R2 masking
    wr(0, 32'hFC00_00F0);
    rd(0, 32'h0000_00F0, "R2 upper control bits dropped");
    // R1 ignored writes
    rdv(4, x);
    wr(4, 32'd5);
    rd(4, x, "R1 count register is read-only");
    wr(6, 32'h55);
    rd(2, 32'd2, "R1 unmapped write leaves load");
    rd(3, 32'd100, "R1 unmapped write leaves compare");
    rd(6, 32'h0, "R1 unmapped offset still reads zero");
    // R11 soft reset
    wr(0, 32'h03FF_FFFF);
    rd(0, 32'h003C_0003, "R11 soft reset keeps only enable bits");
    rd(1, 32'h0, "R11 status cleared");
    rd(2, 32'hFFFF_FFFF, "R11 load set to all ones");
    rd(3, 32'h0, "R11 compare cleared");
    rd(4, 32'hFFFF_FFFF, "R11/R8 rising enable after soft reset starts at all ones");
    wr(0, 32'h03FF_FFFF);
    rd(4, 32'h0, "R11 count cleared without rising enable");
    // R4 gating
    wr(0, 32'h0);
    wr(2, 32'd3);
    wr(3, 32'd1);
    wr(0, 32'h0100_000B);
    repeat (10) @(negedge clk);
    rd(1, 32'd1, "R6 flag set with interrupt disabled");
    chk("R4 irq masked by interrupt enable", {31'd0, irq}, 32'd0);
    wr(0, 32'h0100_000F);
    chk("R4 irq high with flag and enables", {31'd0, irq}, 32'd1);
    wr(0, 32'h0100_000E);
    chk("R4 irq low when timer disabled", {31'd0, irq}, 32'd0);
    repeat (3) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule